// File: doc/BRIEF.md
# Soft-Start Frequency Sweep Sequencer

This block is the digital sequencer for the soft-start of a half-bridge resonant converter. A ramp counter takes the place of the timing capacitor. It can be charged at a fast rate or a slow rate, or drained at a sink rate, and each rate is set by a clock-enable divider.

After reset or after a drain, the ramp first charges quickly up to a start code. It then waits at that code until the control loop reports that its input has settled. Once that happens, the ramp charges slowly and the gate drive is allowed to switch. The ramp code is mapped to a frequency floor for the pulse generator. The floor is six times the minimum frequency at the start code and falls in a straight line to one times the minimum at the end code. Past the end code the soft-start flag drops, and the ramp keeps rising until it saturates at full scale.

A drain request from the protection supervisor has priority over every other input. It stops the gate drive and counts the ramp down to zero. When the ramp is at zero and the request has been released, a new start-up sequence begins.

Top module: `softstart_sweep`

## Requirements
- R1: While reset is high and on release, the ramp code is 0, gate_en and ss_active are 0, and freq_mult is 1536, which is 6.0 in the unsigned fixed-point format with 8 fraction bits where 1.0 equals 256.
- R2: After reset, with no drain request, the ramp code rises by exactly one every FAST_DIV cycles. It stops at the start code 1310, which is 1.6 V on a 12-bit scale where 4095 stands for 5 V. During this phase ss_active is 1 and gate_en is 0.
- R3: At the start code, while ctrl_settled is 0, the ramp holds at 1310 and gate_en stays 0. gate_en is never 1 while the ramp code is below 1310.
- R4: Once ctrl_settled is seen high during the hold, gate_en goes to 1 and the ramp rises by one every SLOW_DIV cycles. A later low level on ctrl_settled has no effect on the ramp or on gate_en.
- R5: ss_active is 1 only while the ramp code is at or below the end code 3439 (4.2 V). After the end code the ramp keeps charging slowly and saturates at 4095, and gate_en stays 1.
- R6: One cycle after a ramp code L, freq_mult shows 1536 when L is at most 1310 and 256 when L is at least 3439. Between those codes it shows 1536 - floor(1280*(L-1310)/2129).
- R7: When discharge is high, gate_en and ss_active go to 0, the ramp never rises, and it falls by one every SINK_DIV cycles until it reaches 0. The fall continues to zero even if discharge is released earlier.
- R8: When the ramp is at 0 during a drain and discharge is low, the sequence restarts with fast charging from 0 as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_settled | input | 1 | The control input has reached its frequency-set level |
| discharge | input | 1 | Drain request from the protection supervisor |
| ramp_level | output | LEVEL_W (12) | Ramp code; full scale stands for 5 V |
| gate_en | output | 1 | Gate drive may switch |
| ss_active | output | 1 | Soft-start sweep is in progress |
| freq_mult | output | FRAC_W+3 (11) | Frequency floor as a multiple of the minimum frequency, 8 fraction bits |

## Verification
The assertions take two things for granted. First, discharge and ctrl_settled change only between clock edges and are already defined at the first edge after reset. Second, only the block's own counter moves the ramp, so any change in the ramp code is a single step. The stimulus drives every input at the falling edge and holds it low from time zero. ctrl_settled is raised only during the hold at the start code and dropped later in the slow sweep. Drain requests are issued both at full scale and in the middle of fast charging, and one of them is released before the ramp reaches zero, so the rule that the drain always finishes is exercised.

// File: rtl/ss_pkg.sv
package ss_pkg;

  typedef enum logic [1:0] {
    PH_FAST  = 2'd0,
    PH_WAIT  = 2'd1,
    PH_SWEEP = 2'd2,
    PH_SINK  = 2'd3
  } ss_phase_e;

  // Convert a millivolt level into a ramp code on a scale where full_mv maps to full_code.
  function automatic int unsigned mv_to_code(int unsigned mv, int unsigned full_mv,
                                             int unsigned full_code);
    return (mv * full_code) / full_mv;
  endfunction

endpackage

// File: rtl/ss_rate_div.sv
module ss_rate_div #(
  parameter int unsigned DIV = 1,
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);

  logic [CW-1:0] cnt;

  assign tick = en && (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R2/R4/R7: the divider count never runs past its terminal value
  a_r2_div_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DIV - 1));

endmodule

// File: rtl/ss_ramp_ctr.sv
module ss_ramp_ctr #(
  parameter int unsigned W   = 12,
  parameter int unsigned MAX = (1 << W) - 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         up,
  input  logic         down,
  output logic [W-1:0] level
);

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= '0;
    end else if (down) begin
      if (level != '0) level <= level - 1'b1;
    end else if (up) begin
      if (level != W'(MAX)) level <= level + 1'b1;
    end
  end

  // R7: a drain step at zero leaves the ramp at zero
  a_r7_no_underflow: assert property (@(posedge clk) disable iff (rst)
    (down && level == '0) |=> level == '0);

  // R5: the ramp saturates at full scale
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (up && !down && level == W'(MAX)) |=> level == W'(MAX));

endmodule

// File: rtl/ss_freq_map.sv
module ss_freq_map #(
  parameter int unsigned W      = 12,
  parameter int unsigned FRAC_W = 8,
  parameter int unsigned LO_LVL = 1310,
  parameter int unsigned HI_LVL = 3439,
  localparam int unsigned MW    = FRAC_W + 3,
  localparam int unsigned ONE   = 1 << FRAC_W,
  localparam int unsigned SIX   = 6 * ONE,
  localparam int unsigned DROP  = 5 * ONE,
  localparam int unsigned SPAN  = HI_LVL - LO_LVL
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  level,
  output logic [MW-1:0] mult
);

  logic [31:0] delta;
  logic [31:0] quot;
  logic [31:0] full;
  logic [MW-1:0] mult_d;

  always_comb begin
    delta = 32'(level) - 32'(LO_LVL);
    quot  = (32'(DROP) * delta) / 32'(SPAN);
    if (32'(level) <= 32'(LO_LVL)) begin
      full = 32'(SIX);
    end else if (32'(level) >= 32'(HI_LVL)) begin
      full = 32'(ONE);
    end else begin
      full = 32'(SIX) - quot;
    end
    mult_d = MW'(full);
  end

  always_ff @(posedge clk) begin
    if (rst) mult <= MW'(SIX);
    else     mult <= mult_d;
  end

  // R6: the floor stays between one and six times the minimum
  a_r6_mult_bounds: assert property (@(posedge clk) disable iff (rst)
    (mult >= MW'(ONE)) && (mult <= MW'(SIX)));

  // R6: a code at or below the start code gives the six-times floor one cycle later
  a_r6_low_gives_six: assert property (@(posedge clk) disable iff (rst)
    (32'(level) <= 32'(LO_LVL)) |=> mult == MW'(SIX));

endmodule

// File: rtl/softstart_sweep.sv
module softstart_sweep #(
  parameter int unsigned LEVEL_W  = 12,
  parameter int unsigned FRAC_W   = 8,
  parameter int unsigned FULL_MV  = 5000,
  parameter int unsigned START_MV = 1600,
  parameter int unsigned END_MV   = 4200,
  parameter int unsigned FAST_DIV = 1,
  parameter int unsigned SLOW_DIV = 100,
  parameter int unsigned SINK_DIV = 4,
  localparam int unsigned MULT_W    = FRAC_W + 3,
  localparam int unsigned MAX_LVL   = (1 << LEVEL_W) - 1,
  localparam int unsigned START_LVL = ss_pkg::mv_to_code(START_MV, FULL_MV, MAX_LVL),
  localparam int unsigned END_LVL   = ss_pkg::mv_to_code(END_MV, FULL_MV, MAX_LVL)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ctrl_settled,
  input  logic               discharge,
  output logic [LEVEL_W-1:0] ramp_level,
  output logic               gate_en,
  output logic               ss_active,
  output logic [MULT_W-1:0]  freq_mult
);

  import ss_pkg::*;

  ss_phase_e phase, phase_nx;
  logic fast_en, slow_en, sink_en;
  logic fast_tick, slow_tick, sink_tick;
  logic below_start, below_end, at_top, at_zero;

  assign below_start = 32'(ramp_level) < 32'(START_LVL);
  assign below_end   = 32'(ramp_level) <= 32'(END_LVL);
  assign at_top      = ramp_level == LEVEL_W'(MAX_LVL);
  assign at_zero     = ramp_level == '0;

  always_comb begin
    phase_nx = phase;
    if (discharge) begin
      phase_nx = PH_SINK;
    end else begin
      case (phase)
        PH_FAST:  if (!below_start) phase_nx = PH_WAIT;
        PH_WAIT:  if (ctrl_settled) phase_nx = PH_SWEEP;
        PH_SWEEP: phase_nx = PH_SWEEP;
        PH_SINK:  if (at_zero) phase_nx = PH_FAST;
        default:  phase_nx = PH_FAST;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_FAST;
    else     phase <= phase_nx;
  end

  assign fast_en = (phase == PH_FAST)  && !discharge && below_start;
  assign slow_en = (phase == PH_SWEEP) && !discharge && !at_top;
  assign sink_en = (phase == PH_SINK)  && !at_zero;

  ss_rate_div #(.DIV(FAST_DIV)) u_fast (.clk(clk), .rst(rst), .en(fast_en), .tick(fast_tick));
  ss_rate_div #(.DIV(SLOW_DIV)) u_slow (.clk(clk), .rst(rst), .en(slow_en), .tick(slow_tick));
  ss_rate_div #(.DIV(SINK_DIV)) u_sink (.clk(clk), .rst(rst), .en(sink_en), .tick(sink_tick));

  ss_ramp_ctr #(.W(LEVEL_W), .MAX(MAX_LVL)) u_ramp (
    .clk(clk), .rst(rst),
    .up(fast_tick || slow_tick),
    .down(sink_tick),
    .level(ramp_level)
  );

  ss_freq_map #(.W(LEVEL_W), .FRAC_W(FRAC_W), .LO_LVL(START_LVL), .HI_LVL(END_LVL)) u_map (
    .clk(clk), .rst(rst), .level(ramp_level), .mult(freq_mult)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_en   <= 1'b0;
      ss_active <= 1'b0;
    end else begin
      gate_en   <= (phase == PH_SWEEP);
      ss_active <= (phase != PH_SINK) && (32'(ramp_level) < 32'(END_LVL));
    end
  end

  // R3: no switching below the start code
  a_r3_gate_above_start: assert property (@(posedge clk) disable iff (rst)
    gate_en |-> (32'(ramp_level) >= 32'(START_LVL)));

  // R5: soft-start flag only up to the end code
  a_r5_ss_below_end: assert property (@(posedge clk) disable iff (rst)
    ss_active |-> below_end);

  // R2: the ramp moves one code at a time
  a_r2_unit_step: assert property (@(posedge clk) disable iff (rst)
    (ramp_level != $past(ramp_level)) |->
      (ramp_level == $past(ramp_level) + 1'b1 || ramp_level == $past(ramp_level) - 1'b1));

  // R7: a drain request forbids any rise
  a_r7_no_rise: assert property (@(posedge clk) disable iff (rst)
    discharge |=> ramp_level <= $past(ramp_level));

  // R7: gate drive stops one cycle after the drain phase begins
  a_r7_gate_off: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SINK) |=> !gate_en);

endmodule

// File: tb/tb_softstart_sweep.sv
module tb_softstart_sweep;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctrl_settled = 1'b0;
  logic        discharge = 1'b0;
  logic [11:0] ramp_level;
  logic        gate_en;
  logic        ss_active;
  logic [10:0] freq_mult;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int prev_lvl = 0;
  bit done = 1'b0;

  typedef struct {
    int    at;
    int    lvl;
    int    tol;
    bit    gate;
    bit    ss;
    string tag;
  } item_t;

  item_t exp_q[$];

  always #5 clk = ~clk;

  softstart_sweep #(.FAST_DIV(1), .SLOW_DIV(20), .SINK_DIV(2)) dut (
    .clk(clk), .rst(rst), .ctrl_settled(ctrl_settled), .discharge(discharge),
    .ramp_level(ramp_level), .gate_en(gate_en), .ss_active(ss_active), .freq_mult(freq_mult)
  );

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  // R6 expected floor from the requirement formula
  function automatic int fmul(int l);
    if (l <= 1310) return 1536;
    if (l >= 3439) return 256;
    return 1536 - (1280 * (l - 1310)) / 2129;
  endfunction

  task automatic push(int at, int lvl, int tol, bit g, bit s, string tag);
    item_t it;
    it.at = at; it.lvl = lvl; it.tol = tol; it.gate = g; it.ss = s; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic wait_cyc(int n);
    while (cyc < n) @(negedge clk);
  endtask

  // Monitor: pop and compare as results appear
  always @(negedge clk) begin
    if (!rst && exp_q.size() > 0 && exp_q[0].at == cyc) begin
      item_t it;
      int d;
      it = exp_q.pop_front();
      d = int'(ramp_level) - it.lvl;
      checks++;
      if (d > it.tol || d < -it.tol || gate_en !== it.gate || ss_active !== it.ss) begin
        errors++;
        $display("FAIL %s cyc %0d: level/gate/ss actual %0d/%0b/%0b expected %0d(+-%0d)/%0b/%0b",
                 it.tag, cyc, ramp_level, gate_en, ss_active, it.lvl, it.tol, it.gate, it.ss);
      end
      checks++;
      if (int'(freq_mult) != fmul(prev_lvl)) begin
        errors++;
        $display("FAIL R6 cyc %0d: freq_mult actual %0d expected %0d",
                 cyc, freq_mult, fmul(prev_lvl));
      end
    end
    prev_lvl = int'(ramp_level);
  end

  // Driver
  initial begin
    push(1000,  1000, 2, 1'b0, 1'b1, "R2");
    push(1500,  1310, 0, 1'b0, 1'b1, "R3");
    push(1700,  1314, 2, 1'b1, 1'b1, "R4");
    push(30000, 2729, 2, 1'b1, 1'b1, "R4");
    push(44000, 3429, 2, 1'b1, 1'b1, "R5");
    push(44400, 3449, 2, 1'b1, 1'b0, "R5");
    push(60000, 4095, 0, 1'b1, 1'b0, "R5");
    push(62001, 3595, 2, 1'b0, 1'b0, "R7");
    push(70000, 0,    0, 1'b0, 1'b0, "R7");
    push(70600, 499,  2, 1'b0, 1'b1, "R8");
    push(71100, 850,  2, 1'b0, 1'b0, "R7");
    push(72000, 400,  2, 1'b0, 1'b0, "R7");
    push(73500, 700,  3, 1'b0, 1'b1, "R8");

    repeat (4) @(posedge clk);
    @(negedge clk);
    checks++;
    if (ramp_level !== 12'd0 || gate_en !== 1'b0 || ss_active !== 1'b0 || freq_mult !== 11'd1536) begin
      errors++;
      $display("FAIL R1: level/gate/ss/mult actual %0d/%0b/%0b/%0d expected 0/0/0/1536",
               ramp_level, gate_en, ss_active, freq_mult);
    end
    rst = 1'b0;

    wait_cyc(1600);  ctrl_settled = 1'b1;  // R4 release the hold
    wait_cyc(20000); ctrl_settled = 1'b0;  // R4 later drop is ignored
    wait_cyc(61000); discharge = 1'b1;     // R7 drain from full scale
    wait_cyc(70100); discharge = 1'b0;     // R8 restart
    wait_cyc(71000); discharge = 1'b1;     // R7 drain during fast charge
    wait_cyc(71200); discharge = 1'b0;     // R7 early release, drain continues

    while (exp_q.size() > 0) @(negedge clk);
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // Watchdog
  always @(posedge clk) begin
    if (!done && cyc > 90000) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: cycle actual %0d expected below 90000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule